// File: doc/BRIEF.md
# Serial-Bus DAC Setting Target

This block is a two-wire serial-bus target that owns a single 8-bit volatile setting for a current-sink DAC. The controller addresses it with a header byte. The header holds a fixed six-bit device address, a program-select bit and a direction bit. With the direction bit clear, the target takes in one data byte. That byte either replaces the setting, or it serves as the trigger for a request to copy the present setting into non-volatile storage. With the direction bit set, the target shifts the setting back out.

A write-enable input gates every change. When it is low, writes and program requests are still acknowledged, but they change nothing. A load strobe from the non-volatile store sets the register at power-up.

SCL and SDA enter through a chain of synchronizing flops. START and STOP are found on SDA edges while SCL is high. SDA is driven only as an open-drain pull-down enable.

The state machine has eight states:
- `ST_IDLE`: no transfer.
- `ST_ADDR`: shifting in the header.
- `ST_ADDR_ACK`: acknowledging the header.
- `ST_WDATA`: shifting in the data byte.
- `ST_WDATA_ACK`: acknowledging the data byte.
- `ST_RDATA`: shifting out the setting.
- `ST_RDATA_ACK`: the controller's acknowledge slot.
- `ST_SKIP`: ignoring the bus until the next START or STOP.

The transitions are:
- START leads from any state to `ST_ADDR`.
- STOP leads from any state to `ST_IDLE`.
- `ST_ADDR` leads to `ST_ADDR_ACK` on an address hit, or to `ST_SKIP` on a miss, at the falling SCL edge after the 8th bit.
- `ST_ADDR_ACK` leads to `ST_RDATA` or `ST_WDATA` at the falling edge of the 9th clock.
- `ST_WDATA` leads to `ST_WDATA_ACK`, and then to `ST_SKIP`.
- `ST_RDATA` leads to `ST_RDATA_ACK` after eight falling edges, and then to `ST_SKIP`.

Top module: `vcom_i2c_target`

## Requirements
- R1: A header whose upper six bits equal 100111 is acknowledged by pulling SDA low during the 9th clock. Any other address is not acknowledged, and SDA stays released until the next START.
- R2: Header bit 0 is the direction (1 = read, 0 = write) and header bit 1 is the program select (1 = register write, 0 = program request).
- R3: A write with program select 1 and write-enable high loads the following data byte, received MSB first, into `dac_o`. The data byte is acknowledged.
- R4: A write with program select 0 and write-enable high acknowledges the data byte and leaves `dac_o` unchanged. It raises `prog_req_o` for exactly one clock, with `prog_data_o` equal to the setting held at that time.
- R5: A read returns the setting MSB first, whatever the value of the program-select bit. SDA is released for the acknowledge slot that follows.
- R6: With write-enable low, writes and program requests are acknowledged but change neither `dac_o` nor raise `prog_req_o`. Reads still return the setting.
- R7: A one-clock high on `nv_load_i` copies `nv_data_i` into `dac_o` on the next clock edge.
- R8: A STOP or a repeated START before a data byte is complete aborts the transfer without changing `dac_o`. A repeated START begins a new header.
- R9: After reset, `dac_o` is 0, SDA is released and `prog_req_o` is low.
- R10: Only one data byte per write is taken. A further byte is not acknowledged and does not change `dac_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| wp_en_i | input | 1 | 1 allows writes and program requests |
| nv_load_i | input | 1 | Strobe: load stored value into the setting |
| nv_data_i | input | 8 | Value from non-volatile storage |
| dac_o | output | 8 | Current DAC setting |
| prog_req_o | output | 1 | One-clock request to store the setting |
| prog_data_o | output | 8 | Value to store, valid with `prog_req_o` |

## Verification
The assertions assume that each SCL phase lasts well beyond the synchronizer depth. They also assume that SDA changes only while SCL is low, except for deliberate START and STOP conditions, and that `wp_en_i` and `nv_load_i` are clean synchronous levels. The stimulus holds every SCL phase for ten system clocks and changes SDA only in the low phase. It drives the write-enable and load inputs on the falling clock edge. A repeated START is always entered by raising SDA before SCL, so that no false STOP can appear.

// File: rtl/vcom_pkg.sv
package vcom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK,
        ST_SKIP
    } vcom_state_e;

endpackage

// File: rtl/vcom_bus_sync.sv
module vcom_bus_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    // STAGES must be at least 2
    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
            scl_q  <= scl_sh[STAGES-1];
            sda_q  <= sda_sh[STAGES-1];
        end
    end

    assign scl_now   = scl_sh[STAGES-1];
    assign sda_lvl   = sda_sh[STAGES-1];
    assign scl_rise  = scl_now & ~scl_q;
    assign scl_fall  = ~scl_now & scl_q;
    assign start_det = scl_now & scl_q & sda_q & ~sda_lvl;
    assign stop_det  = scl_now & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/vcom_cmd_fsm.sv
module vcom_cmd_fsm
    import vcom_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter logic [DATA_W-3:0] DEV_ADDR = 6'b100111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              wp_en,
    input  logic [DATA_W-1:0] cur_val,
    output logic              sda_drive,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wr_val,
    output logic              prog_stb
);

    localparam int unsigned CNT_W   = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    vcom_state_e       state, nxt;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  cnt;
    logic              rw_q;
    logic              psel_q;
    logic              hit;
    logic              byte_done;

    assign hit       = (sh[DATA_W-1:2] == DEV_ADDR);
    assign byte_done = scl_fall && (cnt == FULL);

    // next-state logic
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_ADDR:      if (byte_done) nxt = hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall) nxt = rw_q ? ST_RDATA : ST_WDATA;
                ST_WDATA:     if (byte_done) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_SKIP;
                ST_RDATA:     if (scl_fall && cnt == LAST) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = ST_SKIP;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // shift register, bit counter and header fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh     <= '0;
            cnt    <= '0;
            rw_q   <= 1'b0;
            psel_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        sh  <= {sh[DATA_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end
                    if (byte_done && hit) begin
                        rw_q   <= sh[0];
                        psel_q <= sh[1];
                    end
                end
                ST_WDATA: begin
                    if (scl_rise) begin
                        sh  <= {sh[DATA_W-2:0], sda_lvl};
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (rw_q) sh <= cur_val;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        sh  <= {sh[DATA_W-2:0], 1'b0};
                        cnt <= cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_drive = 1'b0;
        wr_stb    = 1'b0;
        prog_stb  = 1'b0;
        wr_val    = sh;
        unique case (state)
            ST_ADDR_ACK,
            ST_WDATA_ACK: sda_drive = 1'b1;
            ST_RDATA:     sda_drive = ~sh[DATA_W-1];
            ST_WDATA: begin
                wr_stb   = byte_done && psel_q && wp_en;
                prog_stb = byte_done && !psel_q && wp_en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vcom_i2c_target.sv
module vcom_i2c_target #(
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter logic [DATA_W-3:0] DEV_ADDR  = 6'b100111,
    parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              wp_en_i,
    input  logic              nv_load_i,
    input  logic [DATA_W-1:0] nv_data_i,
    output logic [DATA_W-1:0] dac_o,
    output logic              prog_req_o,
    output logic [DATA_W-1:0] prog_data_o
);

    logic              sda_lvl, scl_rise, scl_fall, ev_start, ev_stop;
    logic              bus_wr_stb, bus_prog_stb;
    logic [DATA_W-1:0] bus_wr_val;
    logic [DATA_W-1:0] dac_q;
    logic              prog_q;
    logic [DATA_W-1:0] prog_val_q;

    vcom_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (ev_start),
        .stop_det  (ev_stop)
    );

    vcom_cmd_fsm #(.DATA_W(DATA_W), .DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (ev_start),
        .stop_det  (ev_stop),
        .wp_en     (wp_en_i),
        .cur_val   (dac_q),
        .sda_drive (sda_oe_o),
        .wr_stb    (bus_wr_stb),
        .wr_val    (bus_wr_val),
        .prog_stb  (bus_prog_stb)
    );

    // setting register: storage load wins over a bus write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          dac_q <= RESET_VAL;
        else if (nv_load_i)  dac_q <= nv_data_i;
        else if (bus_wr_stb) dac_q <= bus_wr_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_q     <= 1'b0;
            prog_val_q <= '0;
        end else begin
            prog_q <= bus_prog_stb;
            if (bus_prog_stb) prog_val_q <= dac_q;
        end
    end

    assign dac_o       = dac_q;
    assign prog_req_o  = prog_q;
    assign prog_data_o = prog_val_q;

endmodule

// File: rtl/vcom_i2c_target_chk.sv
module vcom_i2c_target_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_en_i,
    input logic              nv_load_i,
    input logic [DATA_W-1:0] dac_o,
    input logic              prog_req_o,
    input logic [DATA_W-1:0] prog_data_o,
    input logic              sda_oe_o,
    input logic              wr_stb,
    input logic              prog_stb,
    input logic              start_det,
    input logic              stop_det
);

    // R3
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(nv_load_i) && !$past(wr_stb)) |-> $stable(dac_o));

    // R6
    wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wp_en_i) && !$past(nv_load_i)) |-> $stable(dac_o));

    // R6
    prog_wp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> $past(wp_en_i));

    // R4
    prog_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |-> (prog_data_o == $past(dac_o)));

    // R4
    prog_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req_o |=> !prog_req_o);

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, prog_stb}));

    // R8
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_oe_o);

    // R8
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(start_det) |-> !sda_oe_o);

endmodule

bind vcom_i2c_target vcom_i2c_target_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_en_i     (wp_en_i),
    .nv_load_i   (nv_load_i),
    .dac_o       (dac_o),
    .prog_req_o  (prog_req_o),
    .prog_data_o (prog_data_o),
    .sda_oe_o    (sda_oe_o),
    .wr_stb      (bus_wr_stb),
    .prog_stb    (bus_prog_stb),
    .start_det   (ev_start),
    .stop_det    (ev_stop)
);

// File: tb/vcom_i2c_target_test.sv
module vcom_i2c_target_test;

    localparam int HP = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b1;
    logic       nv_load = 1'b0;
    logic [7:0] nv_data = 8'h00;
    logic       sda_oe;
    logic [7:0] dac;
    logic       prog_req;
    logic [7:0] prog_data;
    wire        sda_bus = sda_m & ~sda_oe;

    always #4 clk = ~clk;

    vcom_i2c_target uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .wp_en_i     (wp),
        .nv_load_i   (nv_load),
        .nv_data_i   (nv_data),
        .dac_o       (dac),
        .prog_req_o  (prog_req),
        .prog_data_o (prog_data)
    );

    int       vectors = 0;
    int       miscompares = 0;
    int       prog_seen = 0;
    int       prog_exp = 0;
    logic [7:0] exp_dac = 8'h00;
    bit       transit = 1'b1;
    bit       done = 1'b0;

    // reference model compared every clock
    always @(posedge clk) begin
        #2;
        if (rst_n && !transit) begin
            vectors++;
            if (dac !== exp_dac) begin
                miscompares++;
                $display("FAIL R3 model: dac=%h expected %h", dac, exp_dac);
            end
        end
        if (rst_n && prog_req === 1'b1) begin
            prog_seen++;
            vectors++;
            if (prog_data !== exp_dac) begin
                miscompares++;
                $display("FAIL R4 prog data: %h expected %h", prog_data, exp_dac);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; idle(HP);
        scl_m = 1'b1; idle(HP);
        sda_m = 1'b0; idle(HP);
        scl_m = 1'b0; idle(2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; idle(HP);
        scl_m = 1'b1; idle(HP);
        sda_m = 1'b1; idle(HP);
    endtask

    task automatic clk_bit(input bit b, output bit seen);
        sda_m = b; idle(HP);
        scl_m = 1'b1; idle(HP / 2);
        seen = sda_bus; idle(HP / 2);
        scl_m = 1'b0; idle(2);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clk_bit(v[i], s);
        clk_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input bit mack, output logic [7:0] v);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(~mack, s);
    endtask

    // behavioural model of one header + one data byte write
    task automatic model_write(input logic [7:0] hdr, input logic [7:0] d);
        if (hdr[7:2] == 6'b100111 && !hdr[0] && wp) begin
            if (hdr[1]) exp_dac = d;
            else        prog_exp++;
        end
    endtask

    task automatic do_write(input logic [7:0] hdr, input logic [7:0] d, input string tag);
        bit a1, a2;
        transit = 1'b1;
        bus_start();
        send_byte(hdr, a1);
        send_byte(d, a2);
        bus_stop();
        model_write(hdr, d);
        idle(2);
        transit = 1'b0;
        check(a1 && a2, {tag, " ack"}, {a1, a2}, 2'b11);
    endtask

    task automatic do_read(input logic [7:0] hdr, input string tag);
        bit a1;
        logic [7:0] v;
        bus_start();
        send_byte(hdr, a1);
        read_byte(1'b1, v);
        bus_stop();
        check(a1, {tag, " header ack"}, a1, 1);
        check(v === exp_dac, {tag, " read data"}, v, exp_dac);
    endtask

    initial begin
        bit a1, a2, a3;
        int p0;
        idle(5);
        // R9 reset state
        check(dac === 8'h00, "R9 dac reset", dac, 0);
        check(sda_oe === 1'b0, "R9 sda released", sda_oe, 0);
        check(prog_req === 1'b0, "R9 no request", prog_req, 0);
        rst_n = 1'b1;
        idle(3);
        transit = 1'b0;

        // R7 power-up load
        transit = 1'b1;
        nv_data = 8'h5A; nv_load = 1'b1; idle(1);
        nv_load = 1'b0; exp_dac = 8'h5A; idle(1);
        transit = 1'b0;
        check(dac === 8'h5A, "R7 load", dac, 8'h5A);

        // R1 R2 R3 register write
        do_write(8'h9E, 8'hC3, "R3 write");
        check(dac === 8'hC3, "R3 value", dac, 8'hC3);

        // R5 read, program-select set and clear
        do_read(8'h9F, "R5 P=1");
        do_read(8'h9D, "R5 P=0");

        // R4 program request
        p0 = prog_seen;
        do_write(8'h9C, 8'h11, "R4 program");
        check(prog_seen - p0 == 1, "R4 pulse count", prog_seen - p0, 1);
        check(dac === 8'hC3, "R4 unchanged", dac, 8'hC3);

        // R1 address miss
        transit = 1'b1;
        bus_start();
        send_byte(8'h9A, a1);
        send_byte(8'hFF, a2);
        bus_stop();
        idle(2); transit = 1'b0;
        check(!a1 && !a2, "R1 nack", {a1, a2}, 0);
        check(dac === 8'hC3, "R1 unchanged", dac, 8'hC3);

        // R6 write-enable low
        wp = 1'b0;
        p0 = prog_seen;
        do_write(8'h9E, 8'h22, "R6 write");
        do_write(8'h9C, 8'h33, "R6 program");
        check(prog_seen == p0, "R6 no pulse", prog_seen - p0, 0);
        check(dac === 8'hC3, "R6 unchanged", dac, 8'hC3);
        do_read(8'h9F, "R6 read");
        wp = 1'b1;
        idle(2);

        // R8 stop mid-byte
        transit = 1'b1;
        bus_start();
        send_byte(8'h9E, a1);
        clk_bit(1'b0, a2); clk_bit(1'b1, a2); clk_bit(1'b0, a2); clk_bit(1'b1, a2);
        bus_stop();
        idle(2); transit = 1'b0;
        check(dac === 8'hC3, "R8 stop abort", dac, 8'hC3);

        // R8 repeated start mid-byte, then new write
        transit = 1'b1;
        bus_start();
        send_byte(8'h9E, a1);
        clk_bit(1'b0, a2); clk_bit(1'b0, a2); clk_bit(1'b0, a2);
        check(dac === 8'hC3, "R8 restart abort", dac, 8'hC3);
        bus_start();
        send_byte(8'h9E, a1);
        send_byte(8'h77, a2);
        bus_stop();
        exp_dac = 8'h77;
        idle(2); transit = 1'b0;
        check(a1 && a2, "R8 new header ack", {a1, a2}, 2'b11);
        check(dac === 8'h77, "R8 after restart", dac, 8'h77);

        // R10 second data byte refused
        transit = 1'b1;
        bus_start();
        send_byte(8'h9E, a1);
        send_byte(8'h3C, a2);
        send_byte(8'hFF, a3);
        bus_stop();
        exp_dac = 8'h3C;
        idle(2); transit = 1'b0;
        check(a1 && a2 && !a3, "R10 acks", {a1, a2, a3}, 3'b110);
        check(dac === 8'h3C, "R10 value", dac, 8'h3C);

        check(prog_seen == prog_exp, "R4 total requests", prog_seen, prog_exp);
        idle(5);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule